// File: doc/BRIEF.md
# Window Watchdog with Selectable Period

This block supervises the software that runs the system. It divides each supervision period into two equal halves. In the first half the window is shut, and a clear request counts as a fault. In the second half the window is open, and a clear restarts the period. A clear that comes too early and a period that ends with no clear are handled the same way. Either one raises a reset request for a fixed number of clock cycles and sets a sticky flag that records a watchdog-caused reset.

The period counts ticks of an external timebase. A two-bit select picks one of four lengths, each half the one before it. The block samples the select only when a period restarts, so a change made partway through a period leaves the running period alone. An enable input holds the whole block idle while it is low. A separate strobe clears the sticky flag.

Top module: `win_watchdog`

## Requirements
- R1: After reset, `rst_req`, `wd_flag` and `win_open` are all 0.
- R2: The period in ticks is `BASE_TICKS` shifted left by (3 - `per_sel`). With the default of 4 this gives 32, 16, 8 and 4 ticks for `per_sel` = 0, 1, 2 and 3.
- R3: After a restart, `win_open` stays 0 until half the period's ticks have arrived. It is 1 from then until the next restart.
- R4: A `clr_strobe` while `win_open` is 1 restarts the period and produces no reset request. If it arrives in the same cycle as the final tick, the clear takes priority.
- R5: A `clr_strobe` while `win_open` is 0 (with `en` high) is a fault.
- R6: If a full period of ticks arrives with no accepted clear, a fault occurs on the tick that completes the period.
- R7: A fault raises `rst_req` from the next clock edge for exactly `PULSE_LEN` (default 16) cycles and restarts the period.
- R8: A fault sets `wd_flag`. The flag stays set until `flag_clr` or reset. A fault in the same cycle as `flag_clr` leaves the flag set.
- R9: A change of `per_sel` takes effect only at the next restart, which is a fault, an accepted clear, or `en` low.
- R10: While `en` is 0, the period counter is held at zero, `win_open` is 0, and neither ticks nor clears cause a fault.
- R11: The counter advances only on `tick`. Clock cycles without a tick leave the window state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| en | input | 1 | Watchdog enable |
| tick | input | 1 | Timebase tick, one cycle wide |
| clr_strobe | input | 1 | One-cycle watchdog clear request |
| per_sel | input | 2 | Period select, 0 is the longest |
| flag_clr | input | 1 | One-cycle clear of the sticky flag |
| rst_req | output | 1 | Reset request pulse |
| wd_flag | output | 1 | Sticky watchdog-reset flag |
| win_open | output | 1 | High while the clear window is open |

## Verification
The assertions assume that `tick`, `clr_strobe` and `flag_clr` are single-cycle strobes sampled at the rising edge. They also assume that `per_sel` and `en` are levels that may change in any cycle. The bench drives every input half a cycle before the edge that samples it and reads the outputs just after that edge. It always brings `en` low before starting a new scenario, so each case begins from a known restart, and it lets any reset pulse run out first.

// File: rtl/wdw_pkg.sv
package wdw_pkg;

  // Period length in timebase ticks for a given select code.
  function automatic logic [31:0] period_ticks(input logic [1:0] sel,
                                               input logic [31:0] base);
    return base << (2'd3 - sel);
  endfunction

  // Tick count at which the open half of the period begins.
  function automatic logic [31:0] open_start(input logic [1:0] sel,
                                             input logic [31:0] base);
    return period_ticks(sel, base) >> 1;
  endfunction

endpackage

// File: rtl/wdw_timer.sv
module wdw_timer
  import wdw_pkg::*;
#(
  parameter int unsigned BASE_TICKS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick,
  input  logic       clr_strobe,
  input  logic [1:0] per_sel,
  output logic       win_open,
  output logic       fault_evt,
  output logic       clr_ok
);
  localparam int unsigned MAXP = BASE_TICKS * 8;
  localparam int unsigned CW   = $clog2(MAXP);

  logic [CW-1:0] cnt_q;
  logic [1:0]    sel_q;
  logic [31:0]   cnt_w;
  logic [31:0]   plen;
  logic          early_clr;
  logic          timeout;
  logic          restart;

  assign cnt_w     = 32'(cnt_q);
  assign plen      = period_ticks(sel_q, 32'(BASE_TICKS));
  assign win_open  = en && (cnt_w >= open_start(sel_q, 32'(BASE_TICKS)));
  assign clr_ok    = en && clr_strobe && win_open;
  assign early_clr = en && clr_strobe && !win_open;
  assign timeout   = en && tick && !clr_ok && (cnt_w == plen - 32'd1);
  assign fault_evt = early_clr || timeout;
  assign restart   = !en || fault_evt || clr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sel_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
      sel_q <= per_sel;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/wdw_pulse.sv
module wdw_pulse #(
  parameter int unsigned PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse
);
  localparam int unsigned PW = $clog2(PULSE_LEN + 1);

  logic [PW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               left_q <= '0;
    else if (trig)            left_q <= PW'(PULSE_LEN);
    else if (left_q != '0)    left_q <= left_q - 1'b1;
  end

  assign pulse = (left_q != '0);

endmodule

// File: rtl/wdw_flag.sv
module wdw_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag <= 1'b0;
    else if (set_i) flag <= 1'b1;
    else if (clr_i) flag <= 1'b0;
  end
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog #(
  parameter int unsigned BASE_TICKS = 4,
  parameter int unsigned PULSE_LEN  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick,
  input  logic       clr_strobe,
  input  logic [1:0] per_sel,
  input  logic       flag_clr,
  output logic       rst_req,
  output logic       wd_flag,
  output logic       win_open
);
  logic fault_evt;
  logic clr_ok;

  wdw_timer #(.BASE_TICKS(BASE_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick),
    .clr_strobe(clr_strobe), .per_sel(per_sel),
    .win_open(win_open), .fault_evt(fault_evt), .clr_ok(clr_ok)
  );

  wdw_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .trig(fault_evt), .pulse(rst_req)
  );

  wdw_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_i(fault_evt), .clr_i(flag_clr),
    .flag(wd_flag)
  );

endmodule

// File: rtl/win_watchdog_chk.sv
module win_watchdog_chk #(
  parameter int unsigned PULSE_LEN = 16
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic clr_strobe,
  input logic flag_clr,
  input logic rst_req,
  input logic wd_flag,
  input logic win_open,
  input logic fault_evt,
  input logic clr_ok
);
  localparam int unsigned RW = $clog2(PULSE_LEN + 2);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_q <= '0;
    else if (!rst_req) run_q <= '0;
    else if (run_q != '1) run_q <= run_q + 1'b1;
  end

  // R5
  early_clr_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && clr_strobe && !win_open) |-> fault_evt);

  // R4
  open_clr_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && clr_strobe && win_open) |-> (clr_ok && !fault_evt) ##1 !win_open);

  // R7
  fault_pulses_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> (rst_req && !win_open));

  // R7
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(run_q) <= PULSE_LEN);

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_flag && !flag_clr) |=> wd_flag);

  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> wd_flag);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!fault_evt && !win_open && !clr_ok));

endmodule

bind win_watchdog win_watchdog_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .clr_strobe(clr_strobe),
  .flag_clr(flag_clr), .rst_req(rst_req), .wd_flag(wd_flag),
  .win_open(win_open), .fault_evt(fault_evt), .clr_ok(clr_ok)
);

// File: tb/win_watchdog_bench.sv
`timescale 1ns/1ps
module win_watchdog_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, tick = 1'b0, clr_strobe = 1'b0, flag_clr = 1'b0;
  logic [1:0] per_sel = 2'd0;
  logic rst_req, wd_flag, win_open;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  win_watchdog u_win_watchdog (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .clr_strobe(clr_strobe),
    .per_sel(per_sel), .flag_clr(flag_clr), .rst_req(rst_req),
    .wd_flag(wd_flag), .win_open(win_open)
  );

  // {sel, ticks before clear, expected fault}; default base 4: periods 32/16/8/4
  localparam logic [7:0] VEC [10] = '{
    {2'd0, 5'd15, 1'b1}, {2'd0, 5'd16, 1'b0}, {2'd0, 5'd31, 1'b0},
    {2'd1, 5'd7,  1'b1}, {2'd1, 5'd8,  1'b0}, {2'd2, 5'd3,  1'b1},
    {2'd2, 5'd4,  1'b0}, {2'd3, 5'd0,  1'b1}, {2'd3, 5'd2,  1'b0},
    {2'd3, 5'd3,  1'b0}
  };

  task automatic chk(input logic act, input logic exp, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  task automatic cyc(input logic t, input logic c, input logic f);
    @(negedge clk);
    tick = t; clr_strobe = c; flag_clr = f;
    @(posedge clk); #1;
  endtask

  task automatic drain(input logic [1:0] s);
    en = 1'b0; per_sel = s;
    cyc(0, 0, 1);
    repeat (18) cyc(0, 0, 0);
    en = 1'b1;
    cyc(0, 0, 0);
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1;
    chk(rst_req, 0, "R1 rst_req");
    chk(wd_flag, 0, "R1 wd_flag");
    chk(win_open, 0, "R1 win_open");
    rst_n = 1'b1;

    // Table walk: R2 R3 R4 R5
    for (int i = 0; i < 10; i++) begin
      logic [1:0] s; logic [4:0] k; logic e;
      {s, k, e} = VEC[i];
      drain(s);
      for (int j = 0; j < int'(k); j++) cyc(1, 0, 0);
      chk(win_open, !e, $sformatf("R3 R2 win_open vec%0d", i));
      cyc(0, 1, 0);
      chk(rst_req, e, $sformatf("R4 R5 rst_req vec%0d", i));
      chk(wd_flag, e, $sformatf("R8 wd_flag vec%0d", i));
    end

    // R6 timeout, R7 pulse length
    drain(2'd3);
    repeat (3) cyc(1, 0, 0);
    chk(rst_req, 0, "R6 no fault before end");
    cyc(1, 0, 0);
    chk(rst_req, 1, "R6 timeout fault");
    n = 1;
    for (int j = 0; j < 40; j++) begin
      cyc(0, 0, 0);
      if (rst_req) n++;
      else break;
    end
    chk(n == 16, 1, $sformatf("R7 pulse length %0d", n));
    chk(wd_flag, 1, "R8 flag sticky");
    cyc(0, 0, 1);
    chk(wd_flag, 0, "R8 flag cleared");
    cyc(0, 1, 1);
    chk(wd_flag, 1, "R8 fault beats flag_clr");

    // R4 clear on final tick wins
    drain(2'd3);
    repeat (3) cyc(1, 0, 0);
    cyc(1, 1, 0);
    chk(rst_req, 0, "R4 clear on last tick");

    // R9 select change deferred
    drain(2'd0);
    per_sel = 2'd3;
    repeat (4) cyc(1, 0, 0);
    chk(rst_req, 0, "R9 old period still running");
    repeat (12) cyc(1, 0, 0);
    cyc(0, 1, 0);
    chk(rst_req, 0, "R9 accepted clear");
    repeat (3) cyc(1, 0, 0);
    chk(win_open, 1, "R9 new period window");
    cyc(1, 0, 0);
    chk(rst_req, 1, "R9 new period timeout");

    // R10 disabled
    drain(2'd3);
    en = 1'b0;
    repeat (40) cyc(1, 1, 0);
    chk(rst_req, 0, "R10 no reset when disabled");
    chk(win_open, 0, "R10 window shut when disabled");
    chk(wd_flag, 0, "R10 flag untouched");

    // R11 no ticks
    en = 1'b1; per_sel = 2'd3;
    repeat (50) cyc(0, 0, 0);
    chk(win_open, 0, "R11 no advance without tick");
    chk(rst_req, 0, "R11 no timeout without tick");
    repeat (2) cyc(1, 0, 0);
    chk(win_open, 1, "R11 advance on ticks");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule